// File: doc/BRIEF.md
# Debounced Link Status Mailbox

This block reports the condition of a receiving link to a host through a one-byte status mailbox. Three live signals are watched: a link-up line (low when the link is down) and the two tag bits of the word that the transfer gate most recently pulled from the receive buffer. A tag bit marks a control word and the other marks an error. A change on any of the three is reported only once the new value has been steady for a set number of consecutive clocks (two by default). The report then updates the mailbox and raises a "mailbox full" flag. The host clears that flag by reading the mailbox. The flag, gated by a host enable bit, forms an interrupt request.

The mailbox also shows a sticky overflow indication, which only the logic reset clears. At power-up the block loads the current line values into the mailbox without raising the flag. While the host holds the logic reset, no reports are made. On release of that reset the block loads the current values and raises the flag, so software always sees a fresh report after a reset.

Top module: `link_status_reporter`

## Requirements
- R1: The mailbox byte carries the error tag in bit 0, the control tag in bit 1, the link-up line (0 = link down) in bit 2 and the sticky overflow in bit 3. Bits 7 to 4 always read 0.
- R2: On the first clock after power-up reset is released, with the logic reset low, the mailbox takes the current line values and the full flag stays 0.
- R3: When the three watched lines take a value different from the one in the mailbox and hold it for STABLE_CYCLES consecutive clock samples, the mailbox takes that value on the next clock edge and the full flag is set. With the default of 2, the update is visible after the third rising edge following the input change.
- R4: A new line value that is held for fewer than STABLE_CYCLES clock samples and then reverts causes no mailbox update and leaves the full flag unchanged.
- R5: A one-cycle overflow pulse sets mailbox bit 3 on the next edge. The bit stays set until the logic reset. Setting it neither rewrites bits 2 to 0 nor sets the full flag.
- R6: While the logic reset is high, the full flag and the overflow bit are 0 and bits 2 to 0 of the mailbox do not change. On the first edge after the logic reset falls, the mailbox takes the current line values and the full flag is set.
- R7: A host read clears the full flag on the next edge. If that same edge performs a mailbox update, the flag stays set.
- R8: The interrupt request equals the full flag while the interrupt enable is 1, and is 0 while the enable is 0.
- R9: Each of the three watched lines on its own triggers a report; a change of the link-up line alone is reported exactly like a change of a tag bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-up reset, active low |
| logicReset | input | 1 | Host-controlled logic reset, active high, synchronous |
| linkUpIn | input | 1 | Link line, 0 = link down |
| ctrlTagIn | input | 1 | Control tag of the last word taken by the transfer gate |
| errTagIn | input | 1 | Error tag of the last word taken by the transfer gate |
| ovfPulse | input | 1 | One-cycle pulse marking a receive buffer overflow |
| hostRead | input | 1 | One-cycle strobe: host reads the mailbox |
| irqEnable | input | 1 | Host enable for the interrupt request |
| mailboxByte | output | MBOX_W | Status mailbox contents |
| mailboxFull | output | 1 | Set by each report, cleared by a host read |
| irqReq | output | 1 | Interrupt request |

## Verification
A wrong stability history or stale reported value shows up as a mailbox byte that changes one clock early or late, or that changes after a short glitch. Either is visible at the byte within three edges of the input change. A control sequencer stuck in the wrong phase shows as a missing or extra full flag right after power-up or logic-reset release, on the very first edge. A corrupted flag or sticky bit shows directly on `mailboxFull`, `irqReq` or bit 3 of the byte on the edge after the host read, overflow pulse or reset that should have moved it.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

  localparam int STAT_W = 3;

  typedef enum logic [1:0] {
    ST_PWRUP = 2'd0,
    ST_HOLD  = 2'd1,
    ST_RUN   = 2'd2
  } ctlState_e;

  typedef struct packed {
    logic captureLive;
    logic captureStable;
    logic raiseFull;
    logic dropAll;
  } strobes_t;

endpackage

// File: rtl/lsr_datapath.sv
module lsr_datapath
  import lsr_pkg::*;
#(
  parameter int MBOX_W        = 8,
  parameter int STABLE_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [STAT_W-1:0] statusIn,
  input  logic              ovfPulse,
  input  logic              hostRead,
  input  strobes_t          strobes,
  output logic              changeSeen,
  output logic [MBOX_W-1:0] mailboxByte,
  output logic              mailboxFull
);

  localparam int PAD_W = MBOX_W - STAT_W - 1;

  logic [STAT_W-1:0] hist [STABLE_CYCLES];
  logic [STABLE_CYCLES-1:0] sameVec;
  logic [STAT_W-1:0] reported;
  logic              ovfSticky;
  logic              fullQ;

  // sample history: stage 0 follows the live lines, each later stage the one before
  for (genvar i = 0; i < STABLE_CYCLES; i++) begin : g_hist
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) hist[0] <= '0;
        else       hist[0] <= statusIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) hist[i] <= '0;
        else       hist[i] <= hist[i-1];
      end
    end
    assign sameVec[i] = (hist[i] == hist[0]);
  end

  assign changeSeen = (&sameVec) && (hist[0] != reported);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reported <= '0;
    end else if (strobes.captureLive) begin
      reported <= statusIn;
    end else if (strobes.captureStable) begin
      reported <= hist[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                ovfSticky <= 1'b0;
    else if (strobes.dropAll) ovfSticky <= 1'b0;
    else if (ovfPulse)        ovfSticky <= 1'b1;
  end

  // a report on the same edge as a host read keeps the flag set
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  fullQ <= 1'b0;
    else if (strobes.dropAll)   fullQ <= 1'b0;
    else if (strobes.raiseFull) fullQ <= 1'b1;
    else if (hostRead)          fullQ <= 1'b0;
  end

  assign mailboxByte = {{PAD_W{1'b0}}, ovfSticky, reported};
  assign mailboxFull = fullQ;

endmodule

// File: rtl/lsr_control.sv
module lsr_control
  import lsr_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     logicReset,
  input  logic     changeSeen,
  output strobes_t strobes
);

  ctlState_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_PWRUP;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD  = stateQ;
    strobes = '0;
    if (logicReset) begin
      strobes.dropAll = 1'b1;
      stateD          = ST_HOLD;
    end else begin
      unique case (stateQ)
        ST_PWRUP: begin
          strobes.captureLive = 1'b1;
          stateD              = ST_RUN;
        end
        ST_HOLD: begin
          strobes.captureLive = 1'b1;
          strobes.raiseFull   = 1'b1;
          stateD              = ST_RUN;
        end
        ST_RUN: begin
          if (changeSeen) begin
            strobes.captureStable = 1'b1;
            strobes.raiseFull     = 1'b1;
          end
        end
        default: stateD = ST_RUN;
      endcase
    end
  end

endmodule

// File: rtl/link_status_reporter.sv
module link_status_reporter
  import lsr_pkg::*;
#(
  parameter int MBOX_W        = 8,
  parameter int STABLE_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              logicReset,
  input  logic              linkUpIn,
  input  logic              ctrlTagIn,
  input  logic              errTagIn,
  input  logic              ovfPulse,
  input  logic              hostRead,
  input  logic              irqEnable,
  output logic [MBOX_W-1:0] mailboxByte,
  output logic              mailboxFull,
  output logic              irqReq
);

  logic [STAT_W-1:0] statusIn;
  logic              changeSeen;
  strobes_t          strobes;

  assign statusIn = {linkUpIn, ctrlTagIn, errTagIn};

  lsr_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .logicReset (logicReset),
    .changeSeen (changeSeen),
    .strobes    (strobes)
  );

  lsr_datapath #(
    .MBOX_W        (MBOX_W),
    .STABLE_CYCLES (STABLE_CYCLES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .statusIn    (statusIn),
    .ovfPulse    (ovfPulse),
    .hostRead    (hostRead),
    .strobes     (strobes),
    .changeSeen  (changeSeen),
    .mailboxByte (mailboxByte),
    .mailboxFull (mailboxFull)
  );

  assign irqReq = mailboxFull & irqEnable;

endmodule

// File: rtl/link_status_reporter_chk.sv
module link_status_reporter_chk #(
  parameter int MBOX_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              logicReset,
  input logic              irqEnable,
  input logic [MBOX_W-1:0] mailboxByte,
  input logic              mailboxFull,
  input logic              irqReq
);

  logic [1:0] age;
  logic       armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end
  assign armed = (age == 2'd2);

  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    mailboxByte[MBOX_W-1:4] == '0);

  p_report_sets_full_r3: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$stable(mailboxByte[2:0])) |-> mailboxFull);

  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mailboxByte[3] && !logicReset) |=> mailboxByte[3]);

  p_hold_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    logicReset |=> (!mailboxFull && !mailboxByte[3]));

  p_irq_needs_full_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (mailboxFull && irqEnable));

endmodule

bind link_status_reporter link_status_reporter_chk #(.MBOX_W(MBOX_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .logicReset  (logicReset),
  .irqEnable   (irqEnable),
  .mailboxByte (mailboxByte),
  .mailboxFull (mailboxFull),
  .irqReq      (irqReq)
);

// File: tb/link_status_reporter_tb_top.sv
`timescale 1ns/1ps
module link_status_reporter_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       logicReset = 1'b0;
  logic       linkUpIn = 1'b1;
  logic       ctrlTagIn = 1'b0;
  logic       errTagIn = 1'b1;
  logic       ovfPulse = 1'b0;
  logic       hostRead = 1'b0;
  logic       irqEnable = 1'b0;
  logic [7:0] mailboxByte;
  logic       mailboxFull;
  logic       irqReq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  link_status_reporter dut_i (
    .clk (clk), .rstN (rstN), .logicReset (logicReset),
    .linkUpIn (linkUpIn), .ctrlTagIn (ctrlTagIn), .errTagIn (errTagIn),
    .ovfPulse (ovfPulse), .hostRead (hostRead), .irqEnable (irqEnable),
    .mailboxByte (mailboxByte), .mailboxFull (mailboxFull), .irqReq (irqReq)
  );

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic setLines(input logic [2:0] v);
    {linkUpIn, ctrlTagIn, errTagIn} = v;
  endtask

  task automatic hostReadOnce();
    hostRead = 1'b1;
    tick();
    hostRead = 1'b0;
  endtask

  task automatic t_power_up();
    setLines(3'b101);
    tick(2);
    rstN = 1'b1;
    tick();
    chk("R2 power-up byte", mailboxByte, 8'h05);
    chk("R2 power-up full", {7'd0, mailboxFull}, 8'h00);
    tick(3);
    chk("R1 upper zero, no report", mailboxByte, 8'h05);
    chk("R2 full stays low", {7'd0, mailboxFull}, 8'h00);
  endtask

  task automatic t_link_change();
    setLines(3'b001);
    tick(2);
    chk("R3 not yet reported", mailboxByte, 8'h05);
    chk("R3 full not yet", {7'd0, mailboxFull}, 8'h00);
    tick();
    chk("R9 link-down reported", mailboxByte, 8'h01);
    chk("R3 full set", {7'd0, mailboxFull}, 8'h01);
    hostReadOnce();
    chk("R7 read clears", {7'd0, mailboxFull}, 8'h00);
  endtask

  task automatic t_glitch();
    errTagIn = 1'b0;
    tick();
    errTagIn = 1'b1;
    tick(4);
    chk("R4 glitch byte", mailboxByte, 8'h01);
    chk("R4 glitch full", {7'd0, mailboxFull}, 8'h00);
  endtask

  task automatic t_ctrl_and_irq();
    ctrlTagIn = 1'b1;
    tick(3);
    chk("R9 ctrl tag reported", mailboxByte, 8'h03);
    chk("R8 irq masked", {7'd0, irqReq}, 8'h00);
    irqEnable = 1'b1;
    #1;
    chk("R8 irq enabled", {7'd0, irqReq}, 8'h01);
    hostReadOnce();
    chk("R8 irq drops with flag", {7'd0, irqReq}, 8'h00);
    irqEnable = 1'b0;
  endtask

  task automatic t_read_vs_write();
    errTagIn = 1'b0;
    tick(2);
    hostRead = 1'b1;
    tick();
    hostRead = 1'b0;
    chk("R7 write wins byte", mailboxByte, 8'h02);
    chk("R7 write wins full", {7'd0, mailboxFull}, 8'h01);
    hostReadOnce();
    chk("R7 later read clears", {7'd0, mailboxFull}, 8'h00);
  endtask

  task automatic t_overflow();
    ovfPulse = 1'b1;
    tick();
    ovfPulse = 1'b0;
    chk("R5 overflow shown", mailboxByte, 8'h0A);
    chk("R5 no full on overflow", {7'd0, mailboxFull}, 8'h00);
    hostReadOnce();
    tick(3);
    chk("R5 overflow sticky", mailboxByte, 8'h0A);
  endtask

  task automatic t_logic_reset();
    logicReset = 1'b1;
    tick();
    setLines(3'b111);
    tick(4);
    chk("R6 hold byte frozen, ovf clear", mailboxByte, 8'h02);
    chk("R6 hold full low", {7'd0, mailboxFull}, 8'h00);
    logicReset = 1'b0;
    tick();
    chk("R6 release capture", mailboxByte, 8'h07);
    chk("R6 release full", {7'd0, mailboxFull}, 8'h01);
    hostReadOnce();
    tick(3);
    chk("R6 no extra report", {7'd0, mailboxFull}, 8'h00);
  endtask

  initial begin
    t_power_up();
    t_link_change();
    t_glitch();
    t_ctrl_and_irq();
    t_read_vs_write();
    t_overflow();
    t_logic_reset();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule